// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the slave side of a four-wire serial memory with a byte array held on chip. While chip select is low, it takes 8-bit instructions in MSB first. It returns array bytes or a status byte on a serial output that is driven only while data bits are valid. Four instructions are recognised:

- a sequential array read (03h), followed by a 16-bit start address;
- a status read (05h);
- write-enable set (06h);
- write-enable clear (04h).

An array read has no length limit. The address advances after every byte and wraps from the top of the array to zero. A single parameter selects a 4K-byte or an 8K-byte array. A synchronous fill port loads the array contents. No serial programming instruction is handled here.

All serial inputs are sampled by the system clock. Edges of the serial clock are found by comparing it with its value one cycle earlier. Each high and low phase of the serial clock must last at least two system clock cycles. Input bits are taken on rising serial clock edges and output bits change on falling ones, so idle-low and idle-high clock polarity both work. The output pad is tri-stated outside the block using the output-enable signal.

Top module: `spi_nvm_slave`

## Requirements
- R1: After reset the output enable is low and the write-enable latch is clear, so a status read returns 00h while the busy input is low.
- R2: Opcode 03h followed by a 16-bit address (most significant bit first) returns the byte stored at that address. It is sent MSB first, and its first bit is driven on the falling serial clock edge that follows the last address bit.
- R3: Only the low 12 address bits (4K array) or the low 13 bits (8K array) are used; the higher address bits have no effect.
- R4: Each further byte comes from the next address. After the last location (FFFh for 4K) the next byte comes from 000h, and the read goes on for as long as clocks arrive.
- R5: Opcode 05h returns the status byte, repeated for as long as clocks arrive. Bit 0 is the busy input, bit 1 is the write-enable latch, and bits 7..2 are 0. Busy is sampled at the start of each byte, so status can be read while busy is high.
- R6: Opcode 06h sets the write-enable latch and opcode 04h clears it. The latch changes only on the cycle where the rise of chip select is seen, never on the eighth opcode bit.
- R7: The output enable is low while chip select is high and during opcode and address bits. In a read, the output changes only after a falling serial clock edge.
- R8: Any other opcode keeps the output disabled for the rest of the frame and leaves the latch unchanged.
- R9: Raising chip select before an instruction is complete aborts it with no effect. The next frame is then decoded from its first bit.
- R10: Both clock polarities (idle low and idle high) give identical results.
- R11: A fill write (address, data, enable for one clock) stores the byte that a later array read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out (registered) |
| miso_oe | output | 1 | Output enable for the tri-state pad |
| busy | input | 1 | Internal write cycle in progress, shown in status bit 0 |
| fill_en | input | 1 | Array fill write strobe |
| fill_addr | input | ADDR_W (12 or 13) | Array fill address |
| fill_data | input | 8 | Array fill data |

## Verification
A serial edge is seen on the first system clock after the input changes. A data bit is therefore registered on `miso` one cycle after the falling edge that calls for it, and the latch changes one cycle after chip select rises. The bench holds each serial clock phase for three system clocks. It reads `miso` at the end of the low phase, just before it raises the clock, which is two cycles after the output has settled. Command-only frames are always followed by a status read in a new frame, so each latch result is observed well after the chip-select edge that produced it. Expected bytes come from an arithmetic fill pattern evaluated at the wrapped address.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;
  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_ARRAY,
    ST_STAT,
    ST_IGN
  } cmd_state_t;

  localparam logic [7:0] OP_RD_ARRAY = 8'h03;
  localparam logic [7:0] OP_RD_STAT  = 8'h05;
  localparam logic [7:0] OP_WEL_SET  = 8'h06;
  localparam logic [7:0] OP_WEL_CLR  = 8'h04;
endpackage

// File: rtl/spi_nvm_edges.sv
module spi_nvm_edges (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= sck;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = sck & ~sck_q & ~cs_n;
  assign sck_fall = ~sck & sck_q & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/spi_nvm_array.sv
module spi_nvm_array #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave
  import spi_nvm_pkg::*;
#(
  parameter bit LARGE_ARRAY = 1'b0,
  localparam int ADDR_W = LARGE_ARRAY ? 13 : 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              busy,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [7:0]        fill_data
);
  logic              sck_rise, sck_fall, cs_rise;
  cmd_state_t        state_q;
  logic [3:0]        bit_cnt;
  logic [15:0]       in_sh;
  logic [15:0]       nxt_sh;
  logic [ADDR_W-1:0] ptr_q;
  logic [2:0]        out_cnt;
  logic [7:0]        out_sh;
  logic [7:0]        arr_rdata;
  logic [7:0]        stat_byte;
  logic [7:0]        load_byte;
  logic              wel_q, set_pend, clr_pend;

  spi_nvm_edges u_edges (
    .clk      (clk),
    .rst      (rst),
    .sck      (sck),
    .cs_n     (cs_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise)
  );

  spi_nvm_array #(.AW(ADDR_W)) u_array (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_addr (fill_addr),
    .wr_data (fill_data),
    .rd_addr (ptr_q),
    .rd_data (arr_rdata)
  );

  assign nxt_sh    = {in_sh[14:0], mosi};
  assign stat_byte = {6'b0, wel_q, busy};
  assign load_byte = (state_q == ST_ARRAY) ? arr_rdata : stat_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OPC;
      bit_cnt  <= '0;
      in_sh    <= '0;
      ptr_q    <= '0;
      out_cnt  <= '0;
      out_sh   <= '0;
      miso     <= 1'b0;
      miso_oe  <= 1'b0;
      wel_q    <= 1'b0;
      set_pend <= 1'b0;
      clr_pend <= 1'b0;
    end else if (cs_n) begin
      state_q  <= ST_OPC;
      bit_cnt  <= '0;
      out_cnt  <= '0;
      miso_oe  <= 1'b0;
      set_pend <= 1'b0;
      clr_pend <= 1'b0;
      if (cs_rise) begin
        if (set_pend)      wel_q <= 1'b1;
        else if (clr_pend) wel_q <= 1'b0;
      end
    end else begin
      if (sck_rise) begin
        in_sh <= nxt_sh;
        case (state_q)
          ST_OPC: begin
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt == 4'd7) begin
              bit_cnt <= '0;
              case (nxt_sh[7:0])
                OP_RD_ARRAY: state_q <= ST_ADDR;
                OP_RD_STAT:  state_q <= ST_STAT;
                OP_WEL_SET: begin
                  set_pend <= 1'b1;
                  state_q  <= ST_IGN;
                end
                OP_WEL_CLR: begin
                  clr_pend <= 1'b1;
                  state_q  <= ST_IGN;
                end
                default:     state_q <= ST_IGN;
              endcase
            end
          end
          ST_ADDR: begin
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt == 4'd15) begin
              ptr_q   <= nxt_sh[ADDR_W-1:0];
              state_q <= ST_ARRAY;
            end
          end
          default: ;
        endcase
      end else if (sck_fall && (state_q == ST_ARRAY || state_q == ST_STAT)) begin
        miso_oe <= 1'b1;
        out_cnt <= out_cnt + 3'd1;
        if (out_cnt == 3'd0) begin
          miso   <= load_byte[7];
          out_sh <= {load_byte[6:0], 1'b0};
          if (state_q == ST_ARRAY) ptr_q <= ptr_q + 1'b1;
        end else begin
          miso   <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_nvm_checker.sv
module spi_nvm_checker
  import spi_nvm_pkg::*;
#(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          miso,
  input logic          miso_oe,
  input logic          sck_fall,
  input logic          cs_rise,
  input logic          wel,
  input cmd_state_t    state,
  input logic [AW-1:0] ptr
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!miso_oe && !wel));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARRAY && $past(state) == ST_ARRAY && !$stable(ptr))
      |-> (ptr == $past(ptr) + 1'b1));

  assert_wel_on_cs_rise_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(wel) |-> $past(cs_rise));

  assert_oe_off_when_deselected_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !miso_oe);

  assert_oe_starts_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(miso_oe) |-> $past(sck_fall));

  assert_miso_moves_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (miso_oe && $past(miso_oe) && !$stable(miso)) |-> $past(sck_fall));

  assert_silent_on_unknown_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGN) |-> !miso_oe);
endmodule

bind spi_nvm_slave spi_nvm_checker #(.AW(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .miso     (miso),
  .miso_oe  (miso_oe),
  .sck_fall (sck_fall),
  .cs_rise  (cs_rise),
  .wel      (wel_q),
  .state    (state_q),
  .ptr      (ptr_q)
);

// File: tb/spi_nvm_slave_bench.sv
module spi_nvm_slave_bench;
  localparam int AW   = 12;
  localparam int MASK = (1 << AW) - 1;
  localparam int HP   = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          sck = 1'b0;
  logic          mosi = 1'b0;
  logic          busy = 1'b0;
  logic          fill_en = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [7:0]    fill_data = '0;
  logic          miso, miso_oe;
  logic          cpol = 1'b0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  spi_nvm_slave #(.LARGE_ARRAY(1'b0)) u_spi_nvm_slave (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sck       (sck),
    .mosi      (mosi),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .busy      (busy),
    .fill_en   (fill_en),
    .fill_addr (fill_addr),
    .fill_data (fill_data)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37) + (a >> 7) + 90);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame_begin(input logic idle_high);
    cpol = idle_high;
    sck  = idle_high;
    tick(2);
    cs_n = 1'b0;
    tick(HP);
  endtask

  task automatic frame_end();
    if (!cpol) begin
      sck = 1'b0;
      tick(HP);
    end
    cs_n = 1'b1;
    tick(4);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int n, output logic [7:0] rx,
                           inout logic oe_any);
    rx = '0;
    for (int i = 7; i >= 8 - n; i--) begin
      sck  = 1'b0;
      mosi = tx[i];
      tick(HP);
      rx[i]  = miso;
      oe_any = oe_any | miso_oe;
      sck  = 1'b1;
      tick(HP);
    end
  endtask

  task automatic read_array(input logic idle_high, input logic [15:0] addr, input int n,
                            input string req);
    logic [7:0] rx;
    logic       oe_any;
    oe_any = 1'b0;
    frame_begin(idle_high);
    send_bits(8'h03, 8, rx, oe_any);
    send_bits(addr[15:8], 8, rx, oe_any);
    send_bits(addr[7:0], 8, rx, oe_any);
    chk("R7 oe low during command", int'(oe_any), 0);
    for (int k = 0; k < n; k++) begin
      oe_any = 1'b0;
      send_bits(8'h00, 8, rx, oe_any);
      chk(req, int'(rx), int'(pat((int'(addr) + k) & MASK)));
    end
    chk("R7 oe high during data", int'(miso_oe), 1);
    frame_end();
    chk("R7 oe low after deselect", int'(miso_oe), 0);
  endtask

  task automatic read_status(input logic idle_high, output logic [7:0] st);
    logic oe_any;
    oe_any = 1'b0;
    frame_begin(idle_high);
    send_bits(8'h05, 8, st, oe_any);
    send_bits(8'h00, 8, st, oe_any);
    frame_end();
  endtask

  task automatic command(input logic [7:0] op);
    logic [7:0] rx;
    logic       oe_any;
    oe_any = 1'b0;
    frame_begin(1'b0);
    send_bits(op, 8, rx, oe_any);
    frame_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    logic [7:0] rx;
    logic       oe_any;
    tick(5);
    rst = 1'b0;
    tick(2);
    // R1: reset state
    chk("R1 oe after reset", int'(miso_oe), 0);
    read_status(1'b0, st);
    chk("R1 status after reset", int'(st), 8'h00);

    // R11: load the array
    for (int a = 0; a <= MASK; a++) begin
      fill_en   = 1'b1;
      fill_addr = AW'(a);
      fill_data = pat(a);
      tick(1);
    end
    fill_en = 1'b0;
    tick(2);

    // R2, R4: sequential reads at several starts
    read_array(1'b0, 16'h0000, 6, "R2 R4 read from 0000");
    read_array(1'b0, 16'h0123, 4, "R2 read from 0123");
    read_array(1'b0, 16'h0AFE, 5, "R4 read across page");
    // R3, R4: upper address bits ignored, wrap past top
    read_array(1'b0, 16'hFFFC, 8, "R3 R4 wrap from FFFC");
    read_array(1'b0, 16'h7FFE, 4, "R3 R4 wrap from 7FFE");
    read_array(1'b0, 16'h0FF0, 40, "R4 long read with wrap");
    // R10: idle-high clock
    read_array(1'b1, 16'h0A55, 5, "R10 idle-high read");
    read_array(1'b1, 16'hBFFF, 3, "R10 R3 idle-high wrap");

    // R11: overwrite one byte and read it back
    fill_en = 1'b1; fill_addr = AW'(12'h010); fill_data = 8'hC3;
    tick(1);
    fill_en = 1'b0;
    tick(1);
    oe_any = 1'b0;
    frame_begin(1'b0);
    send_bits(8'h03, 8, rx, oe_any);
    send_bits(8'h00, 8, rx, oe_any);
    send_bits(8'h10, 8, rx, oe_any);
    send_bits(8'h00, 8, rx, oe_any);
    chk("R11 fill write read back", int'(rx), 8'hC3);
    frame_end();

    // R5: busy visible in status
    busy = 1'b1;
    read_status(1'b0, st);
    chk("R5 status with busy", int'(st), 8'h01);
    busy = 1'b0;

    // R6: latch set and clear
    command(8'h06);
    read_status(1'b0, st);
    chk("R6 latch set", int'(st), 8'h02);
    busy = 1'b1;
    read_status(1'b1, st);
    chk("R5 R10 status busy and latch", int'(st), 8'h03);
    busy = 1'b0;

    // R5: status repeats, busy sampled per byte
    busy = 1'b1;
    oe_any = 1'b0;
    frame_begin(1'b0);
    send_bits(8'h05, 8, rx, oe_any);
    send_bits(8'h00, 8, rx, oe_any);
    chk("R5 repeated status byte 1", int'(rx), 8'h03);
    busy = 1'b0;
    send_bits(8'h00, 8, rx, oe_any);
    chk("R5 repeated status byte 2", int'(rx), 8'h02);
    frame_end();

    // R8: unknown opcode silent, latch kept
    oe_any = 1'b0;
    frame_begin(1'b0);
    send_bits(8'hA5, 8, rx, oe_any);
    send_bits(8'h00, 8, rx, oe_any);
    send_bits(8'h00, 8, rx, oe_any);
    send_bits(8'h00, 8, rx, oe_any);
    frame_end();
    chk("R8 unknown opcode oe", int'(oe_any), 0);
    read_status(1'b0, st);
    chk("R8 latch after unknown opcode", int'(st), 8'h02);

    // R6: clear
    command(8'h04);
    read_status(1'b0, st);
    chk("R6 latch cleared", int'(st), 8'h00);

    // R9: aborted set instruction
    oe_any = 1'b0;
    frame_begin(1'b0);
    send_bits(8'h06, 7, rx, oe_any);
    frame_end();
    read_status(1'b0, st);
    chk("R9 aborted set has no effect", int'(st), 8'h00);
    // R9: aborted read address, then a clean read
    oe_any = 1'b0;
    frame_begin(1'b0);
    send_bits(8'h03, 8, rx, oe_any);
    send_bits(8'h01, 8, rx, oe_any);
    send_bits(8'h20, 5, rx, oe_any);
    frame_end();
    chk("R9 aborted read oe", int'(oe_any), 0);
    read_array(1'b0, 16'h0345, 3, "R9 read after abort");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule